// File: doc/BRIEF.md
# LPDDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a mobile low-power DDR SDRAM. It takes the memory from power-up to a state where it will accept normal traffic. After reset it raises clock enable and keeps the command bus idle for a long settling delay. It then issues one precharge of all banks, two auto refreshes and two mode register loads, one for the standard register and one for the extended register. Each command is followed by the idle gap that the memory needs. When the last gap has elapsed, a ready flag goes high and stays high.

All delays are parameters counted in clock cycles: power-up settle, precharge, refresh and mode-register set. The two register values are parameters, and so is the order of the two loads. The synchronous reset input stands for a loss of power. Asserting it at any point abandons the sequence, and releasing it runs the whole sequence again from the start.

Top module: `lpddr_init_seq`

## Requirements
- R1: In every cycle that follows a clock edge at which `rst` was high, `cke` is low, `init_done` is low and the bus carries NOP. NOP means `cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1, with `ba` and `addr` all zero.
- R2: In the first cycle after the edge at which `rst` is first sampled low, `cke` is high. It stays high until the next reset.
- R3: With `cke` high, the bus carries NOP for exactly `T_PWRUP` cycles before the first command.
- R4: The first command is precharge-all: `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, `addr` bit 10 high and all other address and bank bits zero. Exactly `T_RP` NOP cycles follow it.
- R5: Two auto refreshes follow: `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1, with `ba` and `addr` zero. Each is followed by exactly `T_RFC` NOP cycles.
- R6: Two mode loads follow, with all four command lines low. The standard register load drives `ba`=00 with `addr`=`MR_VAL`. The extended register load drives `ba`=10 with `addr`=`EMR_VAL`. Each load is followed by exactly `T_MRD` NOP cycles.
- R7: With `EMR_FIRST`=0 the standard register is loaded first. With `EMR_FIRST`=1 the extended register is loaded first.
- R8: `init_done` rises in the cycle after the last mode-register gap. From then until reset it stays high and the bus carries NOP.
- R9: A reset asserted at any point of the sequence, including after `init_done`, makes the next run repeat the full sequence from R2 onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high; also models a power interruption |
| cke | output | 1 | Memory clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus; carries register values during mode loads |
| init_done | output | 1 | High once the memory is ready for normal commands |

## Verification
The hardest situation to reach is a power interruption that lands in one particular cycle of the sequence. The most telling cycles are the one-cycle command slots and the last cycle of a gap, since a reset there tests whether the counter and state reload cleanly. The bench places the reset directly on the precharge cycle, the first idle cycle, the cycle before ready and the ready cycle itself. It then adds interruptions at random points drawn from a fixed seed. Every rerun is compared cycle by cycle against an expected bus computed from the timing parameters. Two instances with opposite load order run side by side under the same stimulus.

// File: rtl/lpddr_init_pkg.sv
package lpddr_init_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PREA,
        ST_WAIT_RP,
        ST_REF1,
        ST_WAIT_RFC1,
        ST_REF2,
        ST_WAIT_RFC2,
        ST_LMR_A,
        ST_WAIT_MRD_A,
        ST_LMR_B,
        ST_WAIT_MRD_B,
        ST_READY
    } init_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } bus_cmd_t;

    localparam bus_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam bus_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam bus_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam bus_cmd_t CMD_LMR = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    function automatic int unsigned max_of4(int unsigned a, int unsigned b,
                                            int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/lpddr_init_timer.sv
module lpddr_init_timer #(
    parameter int unsigned CNT_W   = 16,
    parameter int unsigned RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (en && (cnt_q != '0)) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= CNT_W'(RST_VAL);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/lpddr_init_cmd_enc.sv
module lpddr_init_cmd_enc
    import lpddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned MR_VAL    = 0,
    parameter int unsigned EMR_VAL   = 0,
    parameter bit          EMR_FIRST = 1'b0
) (
    input  init_state_e       state,
    output bus_cmd_t          cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              ready
);

    localparam logic [BA_W-1:0]   BA_STD   = BA_W'(0);
    localparam logic [BA_W-1:0]   BA_EXT   = BA_W'(2);
    localparam logic [ADDR_W-1:0] PRE_ALL  = ADDR_W'(1) << 10;

    logic [BA_W-1:0]   ba_a, ba_b;
    logic [ADDR_W-1:0] val_a, val_b;

    generate
        if (EMR_FIRST) begin : g_ext_first
            assign ba_a  = BA_EXT;
            assign val_a = ADDR_W'(EMR_VAL);
            assign ba_b  = BA_STD;
            assign val_b = ADDR_W'(MR_VAL);
        end else begin : g_std_first
            assign ba_a  = BA_STD;
            assign val_a = ADDR_W'(MR_VAL);
            assign ba_b  = BA_EXT;
            assign val_b = ADDR_W'(EMR_VAL);
        end
    endgenerate

    always_comb begin
        cmd  = CMD_NOP;
        ba   = '0;
        addr = '0;
        unique case (state)
            ST_PREA: begin
                cmd  = CMD_PRE;
                addr = PRE_ALL;
            end
            ST_REF1, ST_REF2: begin
                cmd = CMD_REF;
            end
            ST_LMR_A: begin
                cmd  = CMD_LMR;
                ba   = ba_a;
                addr = val_a;
            end
            ST_LMR_B: begin
                cmd  = CMD_LMR;
                ba   = ba_b;
                addr = val_b;
            end
            default: begin
                cmd = CMD_NOP;
            end
        endcase
    end

    assign ready = (state == ST_READY);

endmodule

// File: rtl/lpddr_init_seq.sv
module lpddr_init_seq
    import lpddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W    = 14,
    parameter int unsigned BA_W      = 2,
    parameter int unsigned T_PWRUP   = 40000,
    parameter int unsigned T_RP      = 4,
    parameter int unsigned T_RFC     = 22,
    parameter int unsigned T_MRD     = 2,
    parameter int unsigned MR_VAL    = 32'h0032,
    parameter int unsigned EMR_VAL   = 32'h0000,
    parameter bit          EMR_FIRST = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);

    localparam int unsigned T_MAX = max_of4(T_PWRUP, T_RP, T_RFC, T_MRD);
    localparam int unsigned CNT_W = $clog2(T_MAX + 1) + 1;

    typedef struct packed {
        init_state_e state;
        logic        cke;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    bus_cmd_t         cmd;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.cke = 1'b1;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (ctl_q.state)
            ST_PWRUP: begin
                if (ctl_q.cke && tmr_zero) ctl_d.state = ST_PREA;
            end
            ST_PREA: begin
                ctl_d.state = ST_WAIT_RP;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(T_RP - 1);
            end
            ST_WAIT_RP: begin
                if (tmr_zero) ctl_d.state = ST_REF1;
            end
            ST_REF1: begin
                ctl_d.state = ST_WAIT_RFC1;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(T_RFC - 1);
            end
            ST_WAIT_RFC1: begin
                if (tmr_zero) ctl_d.state = ST_REF2;
            end
            ST_REF2: begin
                ctl_d.state = ST_WAIT_RFC2;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(T_RFC - 1);
            end
            ST_WAIT_RFC2: begin
                if (tmr_zero) ctl_d.state = ST_LMR_A;
            end
            ST_LMR_A: begin
                ctl_d.state = ST_WAIT_MRD_A;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(T_MRD - 1);
            end
            ST_WAIT_MRD_A: begin
                if (tmr_zero) ctl_d.state = ST_LMR_B;
            end
            ST_LMR_B: begin
                ctl_d.state = ST_WAIT_MRD_B;
                tmr_load    = 1'b1;
                tmr_val     = CNT_W'(T_MRD - 1);
            end
            ST_WAIT_MRD_B: begin
                if (tmr_zero) ctl_d.state = ST_READY;
            end
            default: begin
                ctl_d.state = ST_READY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q.state <= ST_PWRUP;
            ctl_q.cke   <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    lpddr_init_timer #(
        .CNT_W  (CNT_W),
        .RST_VAL(T_PWRUP - 1)
    ) i_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .en      (ctl_q.cke),
        .zero    (tmr_zero)
    );

    lpddr_init_cmd_enc #(
        .ADDR_W   (ADDR_W),
        .BA_W     (BA_W),
        .MR_VAL   (MR_VAL),
        .EMR_VAL  (EMR_VAL),
        .EMR_FIRST(EMR_FIRST)
    ) i_enc (
        .state(ctl_q.state),
        .cmd  (cmd),
        .ba   (ba),
        .addr (addr),
        .ready(init_done)
    );

    assign cke   = ctl_q.cke;
    assign cs_n  = cmd.cs_n;
    assign ras_n = cmd.ras_n;
    assign cas_n = cmd.cas_n;
    assign we_n  = cmd.we_n;

endmodule

// File: rtl/lpddr_init_seq_chk.sv
module lpddr_init_seq_chk
    import lpddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned BA_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [BA_W-1:0]   ba,
    input logic [ADDR_W-1:0] addr,
    input logic              init_done
);

    bus_cmd_t cmd_w;
    logic     rst_prev_q;

    assign cmd_w = '{cs_n: cs_n, ras_n: ras_n, cas_n: cas_n, we_n: we_n};

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
    end

    // R1: outputs after a reset edge are in their idle state
    always_ff @(posedge clk) begin
        if (rst_prev_q) begin
            assert_reset_idle_R1: assert (!cke && !init_done && cmd_w == CMD_NOP);
        end
    end

    assert_cke_hold_R2: assert property (@(posedge clk) disable iff (rst)
        cke |=> cke);

    assert_no_cmd_without_cke_R3: assert property (@(posedge clk) disable iff (rst)
        !cke |-> (cmd_w == CMD_NOP));

    assert_prea_a10_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == CMD_PRE) |-> addr[10]);

    assert_cmd_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_w != CMD_NOP) |=> (cmd_w == CMD_NOP));

    assert_lmr_bank_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_w == CMD_LMR) |-> (ba == BA_W'(0) || ba == BA_W'(2)));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cmd_w == CMD_NOP && cke));

endmodule

bind lpddr_init_seq lpddr_init_seq_chk #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W)
) i_chk (
    .clk      (clk),
    .rst      (rst),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .ba       (ba),
    .addr     (addr),
    .init_done(init_done)
);

// File: tb/test_lpddr_init_seq.sv
module test_lpddr_init_seq;

    localparam int TPU   = 20;
    localparam int TRP   = 3;
    localparam int TRFC  = 7;
    localparam int TMRD  = 2;
    localparam int MRV   = 'h0032;
    localparam int EMRV  = 'h0020;

    localparam int P_PRE  = TPU;
    localparam int P_R1   = P_PRE + 1 + TRP;
    localparam int P_R2   = P_R1 + 1 + TRFC;
    localparam int P_L1   = P_R2 + 1 + TRFC;
    localparam int P_L2   = P_L1 + 1 + TMRD;
    localparam int P_DONE = P_L2 + 1 + TMRD;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cke_a, cs_a, ras_a, cas_a, we_a, done_a;
    logic [1:0]  ba_a;
    logic [13:0] addr_a;
    logic        cke_b, cs_b, ras_b, cas_b, we_b, done_b;
    logic [1:0]  ba_b;
    logic [13:0] addr_b;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    lpddr_init_seq #(
        .T_PWRUP(TPU), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
        .MR_VAL(MRV), .EMR_VAL(EMRV), .EMR_FIRST(1'b0)
    ) i_lpddr_init_seq (
        .clk(clk), .rst(rst), .cke(cke_a), .cs_n(cs_a), .ras_n(ras_a),
        .cas_n(cas_a), .we_n(we_a), .ba(ba_a), .addr(addr_a), .init_done(done_a)
    );

    lpddr_init_seq #(
        .T_PWRUP(TPU), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD),
        .MR_VAL(MRV), .EMR_VAL(EMRV), .EMR_FIRST(1'b1)
    ) i_lpddr_init_seq_ext (
        .clk(clk), .rst(rst), .cke(cke_b), .cs_n(cs_b), .ras_n(ras_b),
        .cas_n(cas_b), .we_n(we_b), .ba(ba_b), .addr(addr_b), .init_done(done_b)
    );

    // packed view: {done, cs_n, ras_n, cas_n, we_n, ba[1:0], addr[13:0]}
    function automatic logic [20:0] exp_bus(int k, bit ext_first);
        logic [20:0] v;
        v = {1'b0, 4'b0111, 2'b00, 14'h0};
        if (k == P_PRE)               v = {1'b0, 4'b0010, 2'b00, 14'h0400};
        else if (k == P_R1 || k == P_R2) v = {1'b0, 4'b0001, 2'b00, 14'h0};
        else if (k == P_L1)           v = ext_first ? {1'b0, 4'b0000, 2'b10, 14'(EMRV)}
                                                    : {1'b0, 4'b0000, 2'b00, 14'(MRV)};
        else if (k == P_L2)           v = ext_first ? {1'b0, 4'b0000, 2'b00, 14'(MRV)}
                                                    : {1'b0, 4'b0000, 2'b10, 14'(EMRV)};
        else if (k >= P_DONE)         v = {1'b1, 4'b0111, 2'b00, 14'h0};
        return v;
    endfunction

    function automatic string tag_of(int k, bit ext_first);
        if (k < P_PRE)  return "R3";
        if (k < P_R1)   return "R4";
        if (k < P_L1)   return "R5";
        if (k < P_DONE) return ext_first ? "R7" : "R6";
        return "R8";
    endfunction

    task automatic check(string tag, logic [20:0] act, logic [20:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, cycles, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Reset for a few cycles, then release and follow the sequence for limit+1 cycles.
    task automatic run_seq(int limit, bit after_int);
        string pre;
        pre = after_int ? "R9 " : "";
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R1 dev A", {cke_a, done_a, cs_a, ras_a, cas_a, we_a, ba_a, addr_a},
                  {1'b0, 1'b0, 4'b0111, 2'b00, 14'h0});
            check("R1 dev B", {cke_b, done_b, cs_b, ras_b, cas_b, we_b, ba_b, addr_b},
                  {1'b0, 1'b0, 4'b0111, 2'b00, 14'h0});
        end
        rst = 1'b0;
        for (int k = 0; k <= limit; k++) begin
            @(negedge clk);
            check({pre, "R2 cke"}, {20'h0, cke_a & cke_b}, 21'h1);
            check({pre, tag_of(k, 1'b0), " dev A"},
                  {done_a, cs_a, ras_a, cas_a, we_a, ba_a, addr_a}, exp_bus(k, 1'b0));
            check({pre, tag_of(k, 1'b1), " dev B"},
                  {done_b, cs_b, ras_b, cas_b, we_b, ba_b, addr_b}, exp_bus(k, 1'b1));
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed);
        // directed: full sequence with long ready hold
        run_seq(P_DONE + 10, 1'b0);
        // power loss on chosen boundary cycles, each followed by a full rerun
        run_seq(0, 1'b1);
        run_seq(P_DONE + 2, 1'b1);
        run_seq(P_PRE, 1'b1);
        run_seq(P_DONE + 2, 1'b1);
        run_seq(P_PRE + 1, 1'b1);
        run_seq(P_DONE - 1, 1'b1);
        run_seq(P_DONE, 1'b1);
        run_seq(P_DONE + 2, 1'b1);
        // random interruption points
        for (int n = 0; n < 25; n++) begin
            run_seq(int'($urandom_range(P_DONE + 4, 0)), 1'b1);
        end
        run_seq(P_DONE + 6, 1'b1);
        finish_run();
    end

endmodule